// File: doc/BRIEF.md
# Strobed Serial Command Interface for a Display Controller

This block is the host-facing front end of a display controller. A host talks to it over three wires, a strobe, a shift clock and a data line, and reads back over a fourth, open-drain line. Each time the strobe goes low a new transfer starts. The first complete byte of the transfer is a command, and every later byte in the same transfer is data for that command.

Commands choose the display mode, the dimming level and display enable, the operation for data bytes, and the display memory address. Data bytes are either written to display memory through a one-cycle write port, written to the LED register, or ignored while the block shifts out a snapshot of the key matrix or of the switch inputs. The serial wires are brought into the system clock domain by synchronizers, and their edges are found by sampling, so the shift clock must be well below the system clock.

Top module: `vfd_serial_ctrl`

## Requirements
- R1: Data in is taken on each shift clock rise, least significant bit first. Read data changes after each shift clock fall, also least significant bit first.
- R2: While the strobe is high, shift clock edges have no effect. The first complete byte after the strobe falls is a command.
- R3: A strobe rise partway through a byte discards that byte. Bytes completed earlier keep their effect, and the next transfer starts again with a command.
- R4: Bits 7:6 of a command select its class. With 00, bits 3:0 go to `disp_mode` (reset 4'b1111). With 10, bit 3 goes to `disp_on` (reset 0) and bits 2:0 go to `dim_level` (reset 3'b111).
- R5: Class 01 sets data handling. Bits 1:0 pick the operation: 00 write display memory, 01 write LED, 10 read keys, 11 read switches. Bit 2 set means a fixed address, clear means increment. Bit 3 drives `test_mode`. After reset: display memory write, increment, `test_mode`=0.
- R6: Class 11 loads the address from bits 5:0. A value of 0x30 or higher blocks display memory writes until a valid address is loaded. The address resets to 0x00.
- R7: Each display memory data byte pulses `mem_we` once with the current address and the byte. In increment mode the address then advances, and stepping past 0x2F blocks further writes. In fixed mode the address holds.
- R8: An LED data byte loads its bits 4:0 into `led_n`, where 0 lights an LED. Bits 7:5 are ignored. Reset value is 5'b11111.
- R9: A key read streams `key_data` bit 0 first, as sampled when the read command completes. After bit KEY_BITS-1 it wraps to bit 0.
- R10: A switch read streams the byte {4'b0000, `sw_in`}, sampled at the command, and repeats every 8 clocks.
- R11: `dout_pull` is high only while reading, the strobe is low and the current bit is 0. Otherwise the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_strobe | input | 1 | Transfer strobe, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data in |
| dout_pull | output | 1 | 1 pulls the open-drain read line low |
| key_data | input | KEY_BITS | Key matrix state |
| sw_in | input | SW_W | General-purpose switch inputs |
| mem_we | output | 1 | Display memory write strobe |
| mem_addr | output | 6 | Display memory write address |
| mem_wdata | output | 8 | Display memory write data |
| led_n | output | LED_W | LED register, 0 lights |
| disp_mode | output | 4 | Display mode field |
| dim_level | output | 3 | Dimming step |
| disp_on | output | 1 | Display enable |
| test_mode | output | 1 | Test mode flag |

## Verification
A bit counter that has slipped shows up within one byte as a wrong mode, dimming or LED value, or as a write to an unexpected address. A byte start that does not return to zero after the strobe shows up in the next transfer, when its first byte is not taken as a command. A wrong address or address-valid state shows up on the memory write port at the next data byte. A wrong read pointer or snapshot shows up on the read line within eight shift clocks, and the wrap test catches pointer range errors one byte after the last key byte.

// File: rtl/vfd_ser_pkg.sv
package vfd_ser_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 6;
    localparam int ADDR_LIMIT = 48;
    localparam int MODE_W     = 4;
    localparam int DIM_W      = 3;

    typedef enum logic [1:0] {
        CLS_MODE = 2'b00,
        CLS_DATA = 2'b01,
        CLS_CTRL = 2'b10,
        CLS_ADDR = 2'b11
    } cmd_class_t;

    typedef enum logic [1:0] {
        OP_WR_MEM = 2'b00,
        OP_WR_LED = 2'b01,
        OP_RD_KEY = 2'b10,
        OP_RD_SW  = 2'b11
    } data_op_t;

    typedef struct packed {
        logic              valid;
        logic              is_cmd;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    function automatic logic addr_in_range(input logic [ADDR_W-1:0] a);
        return int'(a) < ADDR_LIMIT;
    endfunction

    function automatic cmd_class_t class_of(input logic [BYTE_W-1:0] b);
        return cmd_class_t'(b[7:6]);
    endfunction

endpackage

// File: rtl/vfd_ser_rx.sv
module vfd_ser_rx
    import vfd_ser_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_in,
    input  logic     sclk_in,
    input  logic     din_in,
    output logic     strobe_s,
    output logic     sclk_fall,
    output rx_byte_t rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic strb_m, clk_m, clk_s, clk_p, din_m, din_s;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              first_byte;
    logic              sclk_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_m <= 1'b1; strobe_s <= 1'b1;
            clk_m  <= 1'b1; clk_s    <= 1'b1; clk_p <= 1'b1;
            din_m  <= 1'b0; din_s    <= 1'b0;
        end else begin
            strb_m <= strobe_in; strobe_s <= strb_m;
            clk_m  <= sclk_in;   clk_s    <= clk_m;  clk_p <= clk_s;
            din_m  <= din_in;    din_s    <= din_m;
        end
    end

    assign sclk_rise = clk_s & ~clk_p & ~strobe_s;
    assign sclk_fall = ~clk_s & clk_p & ~strobe_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            first_byte <= 1'b1;
            rx_byte    <= '0;
        end else begin
            rx_byte.valid <= 1'b0;
            if (strobe_s) begin
                bit_cnt    <= '0;
                first_byte <= 1'b1;
            end else if (sclk_rise) begin
                shreg   <= {din_s, shreg[BYTE_W-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    rx_byte.valid  <= 1'b1;
                    rx_byte.is_cmd <= first_byte;
                    rx_byte.data   <= {din_s, shreg[BYTE_W-1:1]};
                    first_byte     <= 1'b0;
                end
            end
        end
    end

    // R3: a high strobe always restarts byte assembly
    assert_cnt_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        strobe_s |=> (bit_cnt == '0));
    // R2: no byte completes in the cycle after the strobe was seen high
    assert_no_byte_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        strobe_s |=> !rx_byte.valid);

endmodule

// File: rtl/vfd_ser_regs.sv
module vfd_ser_regs
    import vfd_ser_pkg::*;
#(
    parameter int LED_W = 5
)(
    input  logic              clk,
    input  logic              rst,
    input  rx_byte_t          rx_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [LED_W-1:0]  led_n,
    output logic [MODE_W-1:0] disp_mode,
    output logic [DIM_W-1:0]  dim_level,
    output logic              disp_on,
    output logic              test_mode
);
    data_op_t          op;
    logic              addr_fixed;
    logic [ADDR_W-1:0] addr;
    logic              addr_ok;
    logic [BYTE_W-1:0] b;

    assign b = rx_byte.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            op         <= OP_WR_MEM;
            addr_fixed <= 1'b0;
            test_mode  <= 1'b0;
            addr       <= '0;
            addr_ok    <= 1'b1;
            led_n      <= '1;
            disp_mode  <= '1;
            dim_level  <= '1;
            disp_on    <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
        end else begin
            mem_we <= 1'b0;
            if (rx_byte.valid && rx_byte.is_cmd) begin
                unique case (class_of(b))
                    CLS_MODE: disp_mode <= b[MODE_W-1:0];
                    CLS_DATA: begin
                        op         <= data_op_t'(b[1:0]);
                        addr_fixed <= b[2];
                        test_mode  <= b[3];
                    end
                    CLS_CTRL: begin
                        disp_on   <= b[3];
                        dim_level <= b[DIM_W-1:0];
                    end
                    CLS_ADDR: begin
                        addr    <= b[ADDR_W-1:0];
                        addr_ok <= addr_in_range(b[ADDR_W-1:0]);
                    end
                endcase
            end else if (rx_byte.valid) begin
                if (op == OP_WR_MEM && addr_ok) begin
                    mem_we    <= 1'b1;
                    mem_addr  <= addr;
                    mem_wdata <= b;
                    if (!addr_fixed) begin
                        addr    <= addr + 1'b1;
                        addr_ok <= addr_in_range(addr + 1'b1);
                    end
                end else if (op == OP_WR_LED) begin
                    led_n <= b[LED_W-1:0];
                end
            end
        end
    end

    // R6: a write never targets an address beyond the memory
    assert_we_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (int'(mem_addr) < ADDR_LIMIT));
    // R7: consecutive write pulses need two separate bytes
    assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
    // R8: the LED register only moves on an LED data byte
    assert_led_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !(rx_byte.valid && !rx_byte.is_cmd && op == OP_WR_LED) |=> $stable(led_n));

endmodule

// File: rtl/vfd_ser_tx.sv
module vfd_ser_tx
    import vfd_ser_pkg::*;
#(
    parameter int KEY_BITS = 48,
    parameter int SW_W     = 4
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe_s,
    input  logic                sclk_fall,
    input  rx_byte_t            rx_byte,
    input  logic [KEY_BITS-1:0] key_data,
    input  logic [SW_W-1:0]     sw_in,
    output logic                dout_pull
);
    localparam int PTR_W = $clog2(KEY_BITS);

    logic                rd_active;
    logic                rd_sw;
    logic [KEY_BITS-1:0] snap;
    logic [PTR_W-1:0]    ptr;
    logic [PTR_W-1:0]    ptr_last;
    logic                out_bit;
    logic                start_rd;

    assign start_rd = rx_byte.valid && rx_byte.is_cmd &&
                      class_of(rx_byte.data) == CLS_DATA && rx_byte.data[1];
    assign ptr_last = rd_sw ? PTR_W'(BYTE_W - 1) : PTR_W'(KEY_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_active <= 1'b0;
            rd_sw     <= 1'b0;
            snap      <= '0;
            ptr       <= '0;
            out_bit   <= 1'b1;
        end else if (strobe_s) begin
            rd_active <= 1'b0;
            out_bit   <= 1'b1;
        end else if (start_rd) begin
            rd_active <= 1'b1;
            rd_sw     <= rx_byte.data[0];
            ptr       <= '0;
            snap      <= rx_byte.data[0] ? KEY_BITS'(sw_in) : key_data;
        end else if (rx_byte.valid && rx_byte.is_cmd) begin
            rd_active <= 1'b0;
            out_bit   <= 1'b1;
        end else if (rd_active && sclk_fall) begin
            out_bit <= snap[ptr];
            ptr     <= (ptr == ptr_last) ? '0 : ptr + 1'b1;
        end
    end

    assign dout_pull = rd_active & ~out_bit;

    // R11: the line is released once the strobe has been seen high
    assert_release_R11: assert property (@(posedge clk) disable iff (rst)
        strobe_s |=> !dout_pull);
    // R9: the read pointer stays within the selected stream
    assert_ptr_range_R9: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < KEY_BITS);
    // R10: switch stream never goes beyond one byte
    assert_sw_ptr_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_active && rd_sw) |-> (int'(ptr) < BYTE_W));

endmodule

// File: rtl/vfd_serial_ctrl.sv
module vfd_serial_ctrl
    import vfd_ser_pkg::*;
#(
    parameter int KEY_BITS = 48,
    parameter int SW_W     = 4,
    parameter int LED_W    = 5
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_strobe,
    input  logic                ser_clk,
    input  logic                ser_din,
    output logic                dout_pull,
    input  logic [KEY_BITS-1:0] key_data,
    input  logic [SW_W-1:0]     sw_in,
    output logic                mem_we,
    output logic [5:0]          mem_addr,
    output logic [7:0]          mem_wdata,
    output logic [LED_W-1:0]    led_n,
    output logic [3:0]          disp_mode,
    output logic [2:0]          dim_level,
    output logic                disp_on,
    output logic                test_mode
);
    logic     strobe_s;
    logic     sclk_fall;
    rx_byte_t rx_byte;

    vfd_ser_rx rx_i (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (ser_strobe),
        .sclk_in   (ser_clk),
        .din_in    (ser_din),
        .strobe_s  (strobe_s),
        .sclk_fall (sclk_fall),
        .rx_byte   (rx_byte)
    );

    vfd_ser_regs #(.LED_W(LED_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .rx_byte   (rx_byte),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .led_n     (led_n),
        .disp_mode (disp_mode),
        .dim_level (dim_level),
        .disp_on   (disp_on),
        .test_mode (test_mode)
    );

    vfd_ser_tx #(.KEY_BITS(KEY_BITS), .SW_W(SW_W)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .strobe_s  (strobe_s),
        .sclk_fall (sclk_fall),
        .rx_byte   (rx_byte),
        .key_data  (key_data),
        .sw_in     (sw_in),
        .dout_pull (dout_pull)
    );

endmodule

// File: tb/vfd_serial_ctrl_tb_top.sv
`timescale 1ns/1ps
module vfd_serial_ctrl_tb_top;
    localparam int HALF = 8;
    localparam logic [47:0] KEYS = 48'h9A3CE15B70D4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_strobe = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
    logic        dout_pull;
    logic [47:0] key_data = KEYS;
    logic [3:0]  sw_in = 4'hA;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [7:0]  mem_wdata;
    logic [4:0]  led_n;
    logic [3:0]  disp_mode;
    logic [2:0]  dim_level;
    logic        disp_on, test_mode;

    int checks = 0, errors = 0, wr_count = 0;
    logic [7:0] mem_model [48];

    always #2.5 clk = ~clk;

    vfd_serial_ctrl dut_i (.*);

    always @(posedge clk) if (!rst && mem_we) begin
        mem_model[mem_addr] <= mem_wdata;
        wr_count <= wr_count + 1;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_clk = 1'b0; ser_din = b; wait_cyc(HALF);
        ser_clk = 1'b1; wait_cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic begin_xfer();
        ser_strobe = 1'b0; wait_cyc(HALF);
    endtask

    task automatic end_xfer();
        wait_cyc(HALF); ser_strobe = 1'b1; wait_cyc(2 * HALF);
    endtask

    task automatic xfer1(input logic [7:0] c);
        begin_xfer(); send_byte(c); end_xfer();
    endtask

    task automatic xfer2(input logic [7:0] c, input logic [7:0] d);
        begin_xfer(); send_byte(c); send_byte(d); end_xfer();
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            ser_clk = 1'b0; wait_cyc(HALF);
            v[i] = ~dout_pull;
            ser_clk = 1'b1; wait_cyc(HALF);
        end
    endtask

    task automatic t_reset();
        check("R4 mode reset", disp_mode, 4'hF);
        check("R4 dim reset", dim_level, 3'h7);
        check("R4 disp_on reset", disp_on, 0);
        check("R5 test reset", test_mode, 0);
        check("R8 led reset", led_n, 5'h1F);
        check("R11 line released", dout_pull, 0);
    endtask

    task automatic t_commands();
        xfer1(8'h8B);
        check("R4 disp_on", disp_on, 1);
        check("R4 dim", dim_level, 3);
        xfer1(8'h0A);
        check("R4 mode", disp_mode, 4'hA);
        xfer1(8'h48);
        check("R5 test bit", test_mode, 1);
        xfer1(8'h40);
        check("R5 test clear", test_mode, 0);
    endtask

    task automatic t_mem_increment();
        int c0 = wr_count;
        begin_xfer(); send_byte(8'hC5); end_xfer();
        begin_xfer(); send_byte(8'h40); send_byte(8'h11);
        send_byte(8'h22); send_byte(8'h33); end_xfer();
        check("R7 write count", wr_count - c0, 3);
        check("R7 addr5", mem_model[5], 8'h11);
        check("R7 addr6", mem_model[6], 8'h22);
        check("R1 addr7 lsb-first", mem_model[7], 8'h33);
    endtask

    task automatic t_mem_fixed();
        int c0;
        mem_model[1] = 8'h00;
        xfer1(8'hC0);
        c0 = wr_count;
        begin_xfer(); send_byte(8'h44); send_byte(8'hA1); send_byte(8'hA2); end_xfer();
        check("R7 fixed count", wr_count - c0, 2);
        check("R7 fixed addr0", mem_model[0], 8'hA2);
        check("R7 fixed addr1 untouched", mem_model[1], 8'h00);
    endtask

    task automatic t_bad_addr();
        int c0 = wr_count;
        xfer1(8'hF0);
        xfer2(8'h40, 8'h55);
        check("R6 addr 0x30 blocks", wr_count - c0, 0);
        xfer1(8'hEF);
        begin_xfer(); send_byte(8'h40); send_byte(8'h77); send_byte(8'h88); end_xfer();
        check("R7 stop past 0x2F", wr_count - c0, 1);
        check("R6 addr 0x2F written", mem_model[47], 8'h77);
        xfer1(8'hC2);
        xfer2(8'h40, 8'h99);
        check("R6 valid addr restores", mem_model[2], 8'h99);
    endtask

    task automatic t_led();
        xfer2(8'h41, 8'hF5);
        check("R8 led low bits", led_n, 5'h15);
    endtask

    task automatic t_strobe_ignore();
        for (int i = 0; i < 8; i++) send_bit(i[0]);
        xfer1(8'h03);
        check("R2 first byte is command", disp_mode, 4'h3);
        check("R2 led untouched", led_n, 5'h15);
    endtask

    task automatic t_abort();
        begin_xfer(); send_byte(8'h41); send_byte(8'h0C);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_xfer();
        check("R3 completed byte kept", led_n, 5'h0C);
        xfer1(8'h8E);
        check("R3 restart as command", dim_level, 3'h6);
        check("R3 led after restart", led_n, 5'h0C);
    endtask

    task automatic t_key_read();
        logic [7:0] v;
        begin_xfer(); send_byte(8'h42); wait_cyc(HALF);
        check("R11 idle before read", dout_pull, 0);
        key_data = 48'h0;
        for (int i = 0; i < 6; i++) begin
            read_byte(v);
            check("R9 key byte", v, KEYS[8*i +: 8]);
        end
        read_byte(v);
        check("R9 key wrap", v, KEYS[7:0]);
        end_xfer();
        check("R11 released after strobe", dout_pull, 0);
        key_data = KEYS;
    endtask

    task automatic t_sw_read();
        logic [7:0] v;
        begin_xfer(); send_byte(8'h43); wait_cyc(HALF);
        read_byte(v);
        check("R10 sw byte", v, 8'h0A);
        read_byte(v);
        check("R10 sw repeat", v, 8'h0A);
        end_xfer();
    endtask

    initial begin
        wait_cyc(5); rst = 1'b0; wait_cyc(5);
        t_reset();
        t_commands();
        t_mem_increment();
        t_mem_fixed();
        t_bad_addr();
        t_led();
        t_strobe_ignore();
        t_abort();
        t_key_read();
        t_sw_read();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule